// File: doc/BRIEF.md
# Selectable-Half Carry-less Multiplier

This block forms the product of two 64-bit polynomials whose coefficients lie in GF(2). Partial products are combined by exclusive-OR, so no carry ever moves between bit positions. The 128-bit result is returned together with a valid flag. Each input operand is 128 bits wide, and an 8-bit immediate chooses which 64-bit half of each operand takes part in the multiply.

A single registered output stage sits behind a valid/ready handshake, so the result appears one cycle after the input is taken. The stage holds a result until the consumer takes it. While such a result is waiting, the block refuses new input. Callers use it as the core of field multiplication or checksum folding, with any reduction done outside the block.

Top module: `clmul_sel`

## Requirements
- R1: Both operands `opa` and `opb` are 128 bits wide. The result `product` is the 128-bit carry-less product of one 64-bit half of `opa` and one 64-bit half of `opb`. The low half is bits [63:0] and the high half is bits [127:64].
- R2: Bit i of a selected half is the coefficient of X^i. Bit k of `product` is the XOR, over every i+j=k, of a[i]&b[j]. No carry passes between bit positions.
- R3: Immediate bit 0 chooses the half of `opa`: 0 selects the low half and 1 selects the high half.
- R4: Immediate bit 4 chooses the half of `opb`: 0 selects the low half and 1 selects the high half. The codes 0x00, 0x01, 0x10 and 0x11 therefore select the pairs low/low, high/low, low/high and high/high, where the first half named belongs to `opa`.
- R5: Immediate bits 1, 2, 3, 5, 6 and 7 have no effect on the result.
- R6: Bit 127 of every delivered product is zero.
- R7: An input is taken on a rising edge where `in_valid` and `in_ready` are both high. `out_valid` is high in the cycle that follows, and `product` then carries that input's result.
- R8: While `out_valid` is high and `out_ready` is low, `in_ready` is low. In the next cycle, `out_valid` stays high and `product` is unchanged.
- R9: While `rst_n` is low, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Operands and immediate are presented |
| in_ready | output | 1 | Block can take an input this cycle |
| opa | input | 128 | Operand A, two 64-bit halves |
| opb | input | 128 | Operand B, two 64-bit halves |
| imm | input | 8 | Half selection: bit 0 for A, bit 4 for B |
| out_valid | output | 1 | `product` holds an undelivered result |
| out_ready | input | 1 | Consumer takes the result this cycle |
| product | output | 128 | Carry-less product |

## Verification
The assertions take for granted that reset is applied before the first edge and that `out_ready` and `in_valid` are never unknown outside reset. They also assume that the operands and the immediate are known in every cycle where an input is taken; otherwise the stability check on `product` would compare unknowns. The stimulus drives every input to a defined value from time zero. It changes inputs only shortly after a rising edge and keeps operands and immediate fixed until they are taken. It toggles `out_ready` at random so that stall cycles also arise.

// File: rtl/clmul_pkg.sv
package clmul_pkg;
  localparam int unsigned HALF_W    = 64;
  localparam int unsigned FULL_W    = 2 * HALF_W;
  localparam int unsigned PROD_W    = 2 * HALF_W;
  localparam int unsigned IMM_W     = 8;
  localparam int unsigned SEL_A_BIT = 0;
  localparam int unsigned SEL_B_BIT = 4;

  typedef logic [HALF_W-1:0] half_t;
  typedef logic [FULL_W-1:0] full_t;
  typedef logic [PROD_W-1:0] prod_t;
endpackage

// File: rtl/clmul_half_sel.sv
module clmul_half_sel #(
  parameter int unsigned WORD_W = 64
) (
  input  logic [2*WORD_W-1:0] word,
  input  logic                pick_hi,
  output logic [WORD_W-1:0]   half
);
  always_comb begin
    if (pick_hi) half = word[2*WORD_W-1:WORD_W];
    else         half = word[WORD_W-1:0];
  end
endmodule

// File: rtl/clmul_array.sv
module clmul_array #(
  parameter int unsigned W = 64
) (
  input  logic [W-1:0]   mul_a,
  input  logic [W-1:0]   mul_b,
  output logic [2*W-1:0] mul_p
);
  localparam int unsigned PW = 2 * W;

  logic [PW-1:0] row [W];

  genvar j;
  generate
    for (j = 0; j < W; j++) begin : g_row
      logic [PW-1:0] shifted;
      assign shifted = {{W{1'b0}}, mul_a} << j;
      assign row[j]  = mul_b[j] ? shifted : '0;
    end
  endgenerate

  always_comb begin
    mul_p = '0;
    for (int k = 0; k < W; k++) begin
      mul_p = mul_p ^ row[k];
    end
  end
endmodule

// File: rtl/clmul_out_stage.sv
module clmul_out_stage #(
  parameter int unsigned DW = 128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          up_valid,
  output logic          up_ready,
  input  logic [DW-1:0] up_data,
  output logic          dn_valid,
  input  logic          dn_ready,
  output logic [DW-1:0] dn_data
);
  logic          valid_q, valid_d;
  logic [DW-1:0] data_q;
  logic          load_en;

  always_comb begin
    up_ready = !valid_q || dn_ready;
    load_en  = up_valid && up_ready;
    valid_d  = valid_q;
    if (load_en)       valid_d = 1'b1;
    else if (dn_ready) valid_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (load_en) data_q <= up_data;
  end

  assign dn_valid = valid_q;
  assign dn_data  = data_q;

  assert_accept_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && up_ready) |=> dn_valid);

  assert_stall_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && !dn_ready) |-> !up_ready);

  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_data)));
endmodule

// File: rtl/clmul_sel.sv
module clmul_sel
  import clmul_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [127:0]  opa,
  input  logic [127:0]  opb,
  input  logic [7:0]    imm,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [127:0]  product
);
  logic  pick_a_hi, pick_b_hi;
  half_t sel_a, sel_b;
  prod_t raw_prod;
  logic  unused_imm_bits;

  assign pick_a_hi       = imm[SEL_A_BIT];
  assign pick_b_hi       = imm[SEL_B_BIT];
  assign unused_imm_bits = ^imm;

  clmul_half_sel #(.WORD_W(HALF_W)) u_sel_a (
    .word(opa), .pick_hi(pick_a_hi), .half(sel_a)
  );

  clmul_half_sel #(.WORD_W(HALF_W)) u_sel_b (
    .word(opb), .pick_hi(pick_b_hi), .half(sel_b)
  );

  clmul_array #(.W(HALF_W)) u_array (
    .mul_a(sel_a), .mul_b(sel_b), .mul_p(raw_prod)
  );

  clmul_out_stage #(.DW(PROD_W)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .up_valid(in_valid),
    .up_ready(in_ready),
    .up_data (raw_prod),
    .dn_valid(out_valid),
    .dn_ready(out_ready),
    .dn_data (product)
  );

  assert_top_bit_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !product[PROD_W-1]);
endmodule

// File: tb/clmul_sel_bench.sv
module clmul_sel_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [127:0] opa = '0;
  logic [127:0] opb = '0;
  logic [7:0]   imm = '0;
  logic         out_valid;
  logic         out_ready = 1'b0;
  logic [127:0] product;

  int checks = 0;
  int errors = 0;
  int ready_pct = 100;
  bit finished = 0;

  logic [127:0] exp_q[$];
  string        tag_q[$];

  always #4 clk = ~clk;

  clmul_sel u_clmul_sel (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .opa(opa), .opb(opb), .imm(imm), .out_valid(out_valid),
    .out_ready(out_ready), .product(product)
  );

  function automatic logic [127:0] ref_mul(logic [63:0] a, logic [63:0] b);
    logic [127:0] acc = '0;
    for (int i = 0; i < 64; i++)
      for (int j = 0; j < 64; j++)
        if (a[i] && b[j]) acc[i+j] = ~acc[i+j];
    return acc;
  endfunction

  task automatic check(string tag, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // random backpressure, driven just after the rising edge
  always @(posedge clk) begin
    #1 out_ready <= ($urandom_range(99) < ready_pct);
  end

  task automatic send(logic [127:0] a, logic [127:0] b, logic [7:0] im, string tag);
    logic [63:0] ha, hb;
    bit taken = 0;
    @(posedge clk); #2;
    opa = a; opb = b; imm = im; in_valid = 1'b1;
    while (!taken) begin
      @(negedge clk);
      taken = in_ready;
      if (taken) begin
        ha = im[0] ? a[127:64] : a[63:0];
        hb = im[4] ? b[127:64] : b[63:0];
        exp_q.push_back(ref_mul(ha, hb));
        tag_q.push_back(tag);
      end
      if (!taken) begin @(posedge clk); #2; end
    end
    @(posedge clk); #2;
    in_valid = 1'b0;
    @(negedge clk);
    check("R7 out_valid after accept", {127'd0, out_valid}, 128'd1);
  endtask

  // scoreboard monitor
  logic         stall_prev = 1'b0;
  logic [127:0] stall_data;
  always @(negedge clk) begin
    if (rst_n) begin
      if (stall_prev) begin
        check("R8 held valid", {127'd0, out_valid}, 128'd1);
        check("R8 held product", product, stall_data);
      end
      stall_prev = 1'b0;
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check("R7 unexpected output", 128'd1, 128'd0);
        end else begin
          automatic logic [127:0] e = exp_q.pop_front();
          automatic string t = tag_q.pop_front();
          check(t, product, e);
          check("R6 top bit", {127'd0, product[127]}, 128'd0);
        end
      end else if (out_valid && !out_ready) begin
        check("R8 in_ready low on stall", {127'd0, in_ready}, 128'd0);
        stall_prev = 1'b1;
        stall_data = product;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [127:0] ra, rb;
    logic [127:0] ones = '1;
    repeat (2) @(negedge clk);
    // R9: reset state
    check("R9 out_valid in reset", {127'd0, out_valid}, 128'd0);
    check("R9 in_ready in reset", {127'd0, in_ready}, 128'd1);
    @(posedge clk); #1 rst_n = 1'b1;

    // R2: single-term products
    send(128'd1, 128'd1, 8'h00, "R2 one times one");
    send({64'd0, 64'd3}, {64'd0, 64'd3}, 8'h00, "R2 (1+X)^2 no carry");
    // R6: highest degree term lands in bit 126
    send({64'd0, 64'h8000_0000_0000_0000}, {64'd0, 64'h8000_0000_0000_0000},
         8'h00, "R6 degree 126");
    // zero and all-ones for every selection, R1 R3 R4
    for (int s = 0; s < 4; s++) begin
      automatic logic [7:0] im = {3'b0, s[1], 3'b0, s[0]};
      send('0, ones, im, "R1 zero operand");
      send(ones, ones, im, "R1 all ones");
    end
    // distinct halves so the selection is visible
    ra = {64'hDEAD_BEEF_0123_4567, 64'h0000_0000_0000_0005};
    rb = {64'h0F0F_1234_5678_9ABC, 64'h0000_0000_0000_0003};
    send(ra, rb, 8'h00, "R3 R4 low low");
    send(ra, rb, 8'h01, "R3 high A low B");
    send(ra, rb, 8'h10, "R4 low A high B");
    send(ra, rb, 8'h11, "R3 R4 high high");
    // R5: other immediate bits ignored
    send(ra, rb, 8'hEE, "R5 bits ignored, low low");
    send(ra, rb, 8'hFF, "R5 bits ignored, high high");
    send(ra, rb, 8'h6B, "R5 bits ignored, high low");

    // random with backpressure
    ready_pct = 50;
    for (int n = 0; n < 200; n++) begin
      ra = {$urandom, $urandom, $urandom, $urandom};
      rb = {$urandom, $urandom, $urandom, $urandom};
      send(ra, rb, 8'($urandom), "R2 random");
    end
    // single-bit operands at random positions
    for (int n = 0; n < 40; n++) begin
      ra = 128'd1 << $urandom_range(127);
      rb = 128'd1 << $urandom_range(127);
      send(ra, rb, 8'($urandom), "R2 single bit");
    end

    ready_pct = 100;
    for (int w = 0; w < 100 && exp_q.size() != 0; w++) @(posedge clk);
    @(negedge clk);
    check("R7 all results delivered", 128'(exp_q.size()), 128'd0);
    summary();
  end
endmodule